// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block decides which of five hardware interrupt lines a small processor core takes next. One line cannot be masked. Three lines are masked one by one and each has a fixed 16-bit vector address. The fifth line, the general line, has no fixed address, so the jump target must come from an outside device. Each line has its own trigger rule. Line A is caught on a rising edge. Lines B and C and the general line act on their level. The non-maskable line needs a rising edge, and the line must still be high when it is sampled.

The core pulses `boundary` each time it finishes an instruction. On that clock edge the block takes the highest-priority qualified line. In the next cycle it raises `irqReq` for one cycle, with either the vector address or the `irqExternal` flag. Taking any line clears the global enable flag. The core sets and clears that flag with single-cycle enable and disable command strobes. A service routine must issue a new enable before another maskable line can be taken. Pushing the stack, fetching instructions and running the external vector cycle all belong to the core.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Priority from highest to lowest is: the non-maskable line, line A, line B, line C, the general line. Only the winner is reported. A loser that still qualifies is reported at a later boundary.
- R2: After a boundary edge that takes a vectored line, `irqReq` is 1 for exactly the next cycle. `irqVector` then holds 0x0024 for the non-maskable line, 0x003C for line A, 0x0034 for line B and 0x002C for line C, and `irqExternal` is 0.
- R3: When the general line is taken, the request cycle shows `irqExternal`=1 and `irqVector`=0x0000.
- R4: A rising edge on line A sets a pending latch. The latch is served even if line A has dropped before the boundary. Holding line A high after it has been served does not request it again.
- R5: Lines B and C and the general line are not latched. They are taken only if they are high on the boundary edge.
- R6: The non-maskable line is taken only after a rising edge, and only if the input is still high at the boundary. A pulse that falls before the boundary is dropped. A line held high is taken once. The line ignores the global enable and the mask bits.
- R7: `cmdEnable` sets the global enable flag and `cmdDisable` clears it. If both arrive in the same cycle, the flag is cleared.
- R8: Lines A, B and C and the general line are taken only while the global enable flag is 1. Mask bits are loaded from `maskData` when `maskWrite` is 1. Bit 0 belongs to line A, bit 1 to line B and bit 2 to line C, and a bit of 1 blocks its line. The general line has no mask bit.
- R9: Taking any line clears the global enable flag. This holds even when `cmdEnable` arrives in the same cycle.
- R10: No request is made unless `boundary` was 1 on the edge before it.
- R11: Reset clears the global enable flag, sets all three mask bits, clears both pending latches and drives all outputs to 0.
- R12: A line A latch that is pending while line A is masked stays pending. It is served after the mask bit is cleared, and only a take or a reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nmiIn | input | 1 | Non-maskable line (edge and level) |
| lineA | input | 1 | Maskable vectored line, edge triggered |
| lineB | input | 1 | Maskable vectored line, level sensitive |
| lineC | input | 1 | Maskable vectored line, level sensitive |
| genIn | input | 1 | General line, level sensitive, vector supplied from outside |
| cmdEnable | input | 1 | Strobe that sets the global enable flag |
| cmdDisable | input | 1 | Strobe that clears the global enable flag |
| maskWrite | input | 1 | Load strobe for the mask bits |
| maskData | input | 3 | New mask bits: bit 0 line A, bit 1 line B, bit 2 line C; 1 blocks |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| irqReq | output | 1 | One-cycle interrupt request |
| irqVector | output | 16 | Vector address during a request, otherwise 0 |
| irqExternal | output | 1 | Request without a fixed vector; the target comes from outside |

## Verification
The bench sends a short line A pulse while line A is masked. A design that does not latch the edge, or that clears the latch on the mask, would never serve it. The bench holds the non-maskable line and line A high after they have been served, and it drops a non-maskable pulse before the boundary. A design that treats either line as level-only would take it again, and one without the level check would serve the dropped pulse. The bench also sends `cmdEnable` together with a take and then with `cmdDisable`. A design with the wrong priority on the enable flag would let a second maskable request through. A reset that lands while a line A edge is pending shows whether reset really clears that latch.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int VEC_W     = 16;
  localparam int NUM_MASKED = 3;  // lines A, B, C
  localparam int NUM_SRC   = 5;

  localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_A   = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_B   = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_C   = 16'h002C;

  // strobes from control to datapath: one bit per line taken at a boundary
  typedef struct packed {
    logic nmi;
    logic a;
    logic b;
    logic c;
    logic gen;
  } take_t;
endpackage

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  nmiIn,
  input  logic                  lineA,
  input  logic                  lineB,
  input  logic                  lineC,
  input  logic                  genIn,
  input  logic                  cmdEnable,
  input  logic                  cmdDisable,
  input  logic                  maskWrite,
  input  logic [NUM_MASKED-1:0] maskData,
  input  take_t                 take,
  output logic                  nmiQual,
  output logic [NUM_MASKED-1:0] maskedQual,
  output logic                  genQual,
  output logic                  ienOut
);
  logic prevNmi, prevA, nmiPend, aPend, ien;
  logic [NUM_MASKED-1:0] maskReg;
  logic [NUM_MASKED-1:0] maskedSrc;
  logic anyTake;

  assign anyTake = |take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevNmi <= 1'b0;
      prevA   <= 1'b0;
      nmiPend <= 1'b0;
      aPend   <= 1'b0;
      ien     <= 1'b0;
      maskReg <= '1;
    end else begin
      prevNmi <= nmiIn;
      prevA   <= lineA;
      // edge sets, a low level discards, a take consumes
      nmiPend <= nmiIn & ((nmiPend & ~take.nmi) | ~prevNmi);
      aPend   <= (aPend & ~take.a) | (lineA & ~prevA);
      if (anyTake || cmdDisable) ien <= 1'b0;
      else if (cmdEnable)        ien <= 1'b1;
      if (maskWrite) maskReg <= maskData;
    end
  end

  assign maskedSrc = {lineC, lineB, aPend};

  for (genvar i = 0; i < NUM_MASKED; i++) begin : g_qual
    assign maskedQual[i] = maskedSrc[i] & ~maskReg[i] & ien;
  end

  assign nmiQual = nmiPend & nmiIn;
  assign genQual = genIn & ien;
  assign ienOut  = ien;

  // R9: any take leaves the enable flag cleared
  p_take_clears_ien_r9: assert property (@(posedge clk) disable iff (!rstN)
    anyTake |=> !ien);
  // R7: disable strobe always wins
  p_disable_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdDisable |=> !ien);
  // R8: maskable lines are never taken with the flag clear
  p_masked_need_ien_r8: assert property (@(posedge clk) disable iff (!rstN)
    (take.a | take.b | take.c | take.gen) |-> ien);
endmodule

// File: rtl/vec_irq_control.sv
module vec_irq_control
  import vec_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  boundary,
  input  logic                  nmiQual,
  input  logic [NUM_MASKED-1:0] maskedQual,
  input  logic                  genQual,
  output take_t                 take,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVector,
  output logic                  irqExternal
);
  logic [VEC_W-1:0] nextVec;

  always_comb begin
    take    = '0;
    nextVec = '0;
    if (boundary) begin
      if (nmiQual) begin
        take.nmi = 1'b1; nextVec = VEC_NMI;
      end else if (maskedQual[0]) begin
        take.a = 1'b1;   nextVec = VEC_A;
      end else if (maskedQual[1]) begin
        take.b = 1'b1;   nextVec = VEC_B;
      end else if (maskedQual[2]) begin
        take.c = 1'b1;   nextVec = VEC_C;
      end else if (genQual) begin
        take.gen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq      <= 1'b0;
      irqVector   <= '0;
      irqExternal <= 1'b0;
    end else begin
      irqReq      <= |take;
      irqVector   <= nextVec;
      irqExternal <= take.gen;
    end
  end

  // R1: at most one line taken per boundary
  p_single_take_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(take));
  // R10: a request only follows a boundary
  p_req_after_boundary_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(boundary));
  // R3: external flag comes with a request and a zero vector
  p_ext_zero_vec_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqExternal |-> (irqReq && irqVector == '0));
  // R6: a non-maskable take needs the line high now
  p_nmi_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    take.nmi |-> nmiQual);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiIn,
  input  logic             lineA,
  input  logic             lineB,
  input  logic             lineC,
  input  logic             genIn,
  input  logic             cmdEnable,
  input  logic             cmdDisable,
  input  logic             maskWrite,
  input  logic [2:0]       maskData,
  input  logic             boundary,
  output logic             irqReq,
  output logic [15:0]      irqVector,
  output logic             irqExternal
);
  take_t take;
  logic nmiQual, genQual, ienOut;
  logic [NUM_MASKED-1:0] maskedQual;

  vec_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .lineA(lineA), .lineB(lineB),
    .lineC(lineC), .genIn(genIn), .cmdEnable(cmdEnable),
    .cmdDisable(cmdDisable), .maskWrite(maskWrite), .maskData(maskData),
    .take(take), .nmiQual(nmiQual), .maskedQual(maskedQual),
    .genQual(genQual), .ienOut(ienOut)
  );

  vec_irq_control u_ctl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiQual(nmiQual),
    .maskedQual(maskedQual), .genQual(genQual), .take(take),
    .irqReq(irqReq), .irqVector(irqVector), .irqExternal(irqExternal)
  );

  // R11: outputs are quiet right after reset ends
  p_quiet_after_reset_r11: assert property (@(posedge clk)
    $rose(rstN) |-> (!irqReq && irqVector == '0 && !irqExternal));
  // R8: a maskable request needs the enable flag set on the edge before
  p_req_needs_ien_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqVector != 16'h0024) |-> $past(ienOut));
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic nmiIn = 0, lineA = 0, lineB = 0, lineC = 0, genIn = 0;
  logic cmdEnable = 0, cmdDisable = 0, maskWrite = 0, boundary = 0;
  logic [2:0] maskData = 3'b000;
  logic irqReq, irqExternal;
  logic [15:0] irqVector;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { logic req; logic [15:0] vec; logic ext; string tag; } exp_t;
  exp_t expQ[$];

  localparam logic [15:0] NONE = 16'h0000;

  always #10 clk = ~clk;  // 50 MHz

  vec_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .lineA(lineA), .lineB(lineB),
    .lineC(lineC), .genIn(genIn), .cmdEnable(cmdEnable),
    .cmdDisable(cmdDisable), .maskWrite(maskWrite), .maskData(maskData),
    .boundary(boundary), .irqReq(irqReq), .irqVector(irqVector),
    .irqExternal(irqExternal)
  );

  // monitor: compares the registered outputs 5 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if (irqReq !== e.req || irqVector !== e.vec || irqExternal !== e.ext) begin
          bad++;
          $display("FAIL %s: got req=%0b vec=%h ext=%0b, want req=%0b vec=%h ext=%0b",
                   e.tag, irqReq, irqVector, irqExternal, e.req, e.vec, e.ext);
        end
      end
    end
  end

  // driver: inputs already set at a falling edge; push what the next edge yields
  task automatic tick(input logic r, input logic [15:0] v, input logic x, input string tag);
    exp_t e;
    e.req = r; e.vec = v; e.ext = x; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    boundary = 0; cmdEnable = 0; cmdDisable = 0; maskWrite = 0;
  endtask

  task automatic quiet(input string tag);
    tick(1'b0, NONE, 1'b0, tag);
  endtask

  task automatic enable();
    cmdEnable = 1; quiet("R7 enable cycle");
  endtask

  task automatic setMask(input logic [2:0] m);
    maskWrite = 1; maskData = m; quiet("R8 mask write cycle");
  endtask

  task automatic atBoundary(input logic r, input logic [15:0] v, input logic x, input string tag);
    boundary = 1; tick(r, v, x, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (irqReq !== 0 || irqVector !== 0 || irqExternal !== 0) begin
      bad++; $display("FAIL R11 outputs in reset: req=%0b vec=%h ext=%0b, want 0", irqReq, irqVector, irqExternal);
    end
    rstN = 1;
    @(negedge clk);
    quiet("R11 idle after reset");
    // R11: enable clear and masks set out of reset
    lineB = 1; atBoundary(0, NONE, 0, "R11 ien clear at reset");
    enable(); atBoundary(0, NONE, 0, "R11 masks set at reset");
    setMask(3'b000);
    // R2 line B vector, then R9 flag cleared by the take
    atBoundary(1, 16'h0034, 0, "R2 line B vector");
    atBoundary(0, NONE, 0, "R9 no retake without enable");
    enable(); atBoundary(1, 16'h0034, 0, "R5 level B still high");
    // R1 priority among B, C, general
    lineC = 1; genIn = 1;
    enable(); atBoundary(1, 16'h0034, 0, "R1 B over C and general");
    lineB = 0;
    enable(); atBoundary(1, 16'h002C, 0, "R2 line C vector / R1 C over general");
    lineC = 0;
    enable(); atBoundary(1, NONE, 1, "R3 general external");
    genIn = 0;
    // R5 level not latched
    enable();
    lineC = 1; quiet("R5 C high no boundary");
    lineC = 0; quiet("R5 C low");
    atBoundary(0, NONE, 0, "R5 C pulse not latched");
    // R4 line A edge latched
    lineA = 1; quiet("R4 A edge");
    lineA = 0; quiet("R4 A falls");
    atBoundary(1, 16'h003C, 0, "R4 A served after fall / R2 A vector");
    lineA = 1; enable();
    atBoundary(1, 16'h003C, 0, "R4 new A edge served");
    enable(); atBoundary(0, NONE, 0, "R4 held A not retaken");
    lineA = 0; quiet("R4 A low");
    // R1 A over B
    enable(); lineB = 1; lineA = 1; quiet("R1 A and B raised");
    atBoundary(1, 16'h003C, 0, "R1 A over B");
    enable(); atBoundary(1, 16'h0034, 0, "R1 B after A");
    lineB = 0; lineA = 0;
    // R12 / R8 masks
    setMask(3'b001);
    lineA = 1; quiet("R12 A edge while masked");
    lineA = 0; enable();
    atBoundary(0, NONE, 0, "R12 masked A not taken");
    setMask(3'b000);
    atBoundary(1, 16'h003C, 0, "R12 pending A served after unmask");
    setMask(3'b010); enable(); lineB = 1;
    atBoundary(0, NONE, 0, "R8 B mask blocks");
    lineB = 0; setMask(3'b100); lineC = 1;
    atBoundary(0, NONE, 0, "R8 C mask blocks");
    setMask(3'b000);
    atBoundary(1, 16'h002C, 0, "R8 C served after unmask");
    lineC = 0; setMask(3'b111); enable(); genIn = 1;
    atBoundary(1, NONE, 1, "R8 general has no mask bit");
    // R8 flag clear blocks, R7 disable wins
    setMask(3'b000); lineB = 1;
    atBoundary(0, NONE, 0, "R8 flag clear blocks B and general");
    cmdEnable = 1; cmdDisable = 1; quiet("R7 both commands");
    atBoundary(0, NONE, 0, "R7 disable wins over enable");
    genIn = 0; lineB = 0;
    // R6 non-maskable line
    setMask(3'b111);
    nmiIn = 1; quiet("R6 nmi edge");
    atBoundary(1, 16'h0024, 0, "R6 nmi ignores flag and masks / R2 vector");
    atBoundary(0, NONE, 0, "R6 held nmi not retaken");
    nmiIn = 0; quiet("R6 nmi low");
    nmiIn = 1; quiet("R6 nmi pulse");
    nmiIn = 0; quiet("R6 nmi pulse ends");
    atBoundary(0, NONE, 0, "R6 dropped nmi pulse");
    setMask(3'b000); enable(); lineB = 1; nmiIn = 1; quiet("R1 nmi and B raised");
    atBoundary(1, 16'h0024, 0, "R1 nmi over B");
    enable(); atBoundary(1, 16'h0034, 0, "R1 B after nmi");
    nmiIn = 0;
    // R10 only at boundary
    enable();
    quiet("R10 no boundary 1");
    quiet("R10 no boundary 2");
    atBoundary(1, 16'h0034, 0, "R10 taken at boundary");
    // R9 take wins over simultaneous enable
    enable();
    cmdEnable = 1; atBoundary(1, 16'h0034, 0, "R9 take with enable");
    atBoundary(0, NONE, 0, "R9 flag cleared despite enable");
    lineB = 0;
    // R11 reset clears pending A
    lineA = 1; quiet("R11 A edge before reset");
    lineA = 0; quiet("R11 A low");
    rstN = 0; @(negedge clk); rstN = 1; @(negedge clk);
    setMask(3'b000); enable();
    atBoundary(0, NONE, 0, "R11 reset cleared pending A");
    quiet("R11 final idle");
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule